// File: doc/BRIEF.md
# Memory-Mapped Real-Time Clock Register Window

This block gives a byte-wide host bus one 32K address space in which ordinary storage and a real-time clock share the same bus cycles. The top eight byte addresses hold a control register and seven time registers. Every other address reaches a synchronous SRAM array. The host reads and writes the clock exactly as it reads and writes memory.

The time registers are a user copy of an external BCD counter, which is not part of this block. The external counter advances on a one-second strobe, shows its current value on a snapshot port, and accepts a new value from a load port. The running count never stops. Two control bits change only the user copy. The freeze bit holds the copy still so that a multi-byte read stays consistent. The set bit stages new time values, and when it clears, those values are handed to the counter through the load port.

A power-fail input blocks every access while it is high and is reflected on an active-low status output. Read data is registered. The bus output is driven only while the access is enabled.

Top module: `clkreg_mem`

## Requirements
- R1: Address 0x7FF8 is control. Addresses 0x7FF9 to 0x7FFF are the time registers, in the order seconds, minutes, hours, day, date, month, year. Every lower address reaches the RAM array through its low RAM_AW bits, so with the default RAM_AW of 11, addresses 0x0001 and 0x0801 are the same byte.
- R2: A cycle with bus_sel_i=1 and bus_wr_i=1 is a write. A cycle with bus_sel_i=1 and bus_wr_i=0 is a read, and its data appears on bus_rdata_o one clock later.
- R3: bus_drive_o is 1 exactly when bus_sel_i=1, bus_oe_i=1, bus_wr_i=0 and pwr_fail_i=0. While bus_drive_o is 0, bus_rdata_o reads 0x00.
- R4: While control bit 6 (freeze) is 1, the time registers keep the values they held when the bit was set, and ticks do not change them.
- R5: When a control write leaves both bit 7 and bit 6 at 0 after at least one of them was 1, the time registers stay unchanged until the next tick_i. On that tick, all seven are reloaded from the snapshot together.
- R6: While neither control bit is set and no refresh is pending, the time registers follow cnt_now_i with one clock of lag. Byte 0 of cnt_now_i is seconds and byte 6 is year.
- R7: Control bit 7 (set) halts refresh of the time registers. A host write to a time register takes effect only while bit 7 is 1. At any other time the write is ignored.
- R8: When a control write changes bit 7 from 1 to 0, cnt_load_o pulses high for exactly one clock, in the cycle after the write. During that pulse, cnt_load_val_o carries the staged time values.
- R9: Unused bits are stored and read as 0. Control keeps only bits 7:6. The writable bit masks are seconds 0x7F, minutes 0x7F, hours 0x3F, day 0x07, date 0x3F, month 0x1F and year 0xFF. Both host writes and snapshots pass through these masks.
- R10: While pwr_fail_i is 1, no RAM or register write takes effect, no read output is driven, and pwr_fail_n_o is 0. Otherwise pwr_fail_n_o is 1.
- R11: A register read in the same cycle as the tick that updates the time registers returns the value from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_fail_i | input | 1 | Supply out of range; blocks every access |
| pwr_fail_n_o | output | 1 | Active-low power-fail status |
| bus_sel_i | input | 1 | Chip select, active high |
| bus_wr_i | input | 1 | Write enable, active high |
| bus_oe_i | input | 1 | Output enable, active high |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data, 0 when not driven |
| bus_drive_o | output | 1 | Read data is being driven |
| tick_i | input | 1 | One-second timebase strobe |
| cnt_now_i | input | 56 | Snapshot of the running BCD counter, seconds in byte 0 |
| cnt_load_o | output | 1 | One-clock strobe that loads the counter |
| cnt_load_val_o | output | 56 | Values to load, same byte layout |

## Verification
Two events can land on the same clock edge: the tick that refreshes the user copy, and a host read of a time register. The bench provokes this in two cases. The first is free-running mode. The second is the pending refresh that follows clearing the freeze bit. In each case it holds tick_i high during the read request, then expects the value from before the edge. A second read, issued two clocks later, must return the new counter value.

// File: rtl/clkreg_pkg.sv
// Shared types and field masks for the clock register window.
// Assumes seven time bytes, with seconds in byte 0 and year in byte 6.
package clkreg_pkg;

    localparam int TIME_BYTES = 7;
    localparam int TIME_W     = TIME_BYTES * 8;

    typedef logic [TIME_BYTES-1:0][7:0] time_vec_t;

    // Control register: only the two top bits are stored.
    typedef struct packed {
        logic set_b;   // bit 7: stage new time values
        logic frz_b;   // bit 6: freeze user copy
    } ctl_t;

    // Writable bits of each time byte, by byte index.
    function automatic logic [7:0] time_field_mask(input logic [2:0] k);
        case (k)
            3'd0:    return 8'h7F;
            3'd1:    return 8'h7F;
            3'd2:    return 8'h3F;
            3'd3:    return 8'h07;
            3'd4:    return 8'h3F;
            3'd5:    return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    // Apply all field masks to a full time vector.
    function automatic time_vec_t mask_time(input time_vec_t v);
        time_vec_t r;
        for (int k = 0; k < TIME_BYTES; k++) begin
            r[k] = v[k] & time_field_mask(3'(k));
        end
        return r;
    endfunction

endpackage

// File: rtl/clkreg_sram.sv
// Single-port synchronous byte array.
// Write and read share one address. Read data is registered and valid one clock
// after the request. The array itself has no reset.
module clkreg_sram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic          re_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [0:DEPTH-1];
    logic [DW-1:0] rdata_q;

    // Store write data into the array.
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    // Capture read data on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (re_i) begin
            rdata_q <= mem_q[addr_i];
        end
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/clkreg_bus.sv
// Bus front end: applies power-fail gating, splits the address space between
// the register window and RAM, and registers the read source and register data.
// Assumes one access per clock and that the RAM returns read data one clock late.
module clkreg_bus #(
    parameter int ADDR_W = 15,
    parameter int RAM_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic              oe_i,
    input  logic              pf_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        ram_rdata_i,
    input  logic [7:0]        reg_rdata_i,
    output logic              ram_we_o,
    output logic              ram_re_o,
    output logic [RAM_AW-1:0] ram_addr_o,
    output logic              reg_we_o,
    output logic [2:0]        reg_idx_o,
    output logic              drive_o,
    output logic [7:0]        rdata_o
);
    logic       acc_en;
    logic       hit_reg;
    logic       src_reg_q;
    logic [7:0] reg_hold_q;

    assign acc_en     = sel_i & ~pf_i;
    assign hit_reg    = &addr_i[ADDR_W-1:3];
    assign ram_we_o   = acc_en & wr_i & ~hit_reg;
    assign ram_re_o   = acc_en & ~wr_i & ~hit_reg;
    assign reg_we_o   = acc_en & wr_i & hit_reg;
    assign reg_idx_o  = addr_i[2:0];
    assign ram_addr_o = addr_i[RAM_AW-1:0];

    // Remember which side answered the last read, and hold register data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_reg_q  <= 1'b0;
            reg_hold_q <= '0;
        end else if (acc_en && !wr_i) begin
            src_reg_q <= hit_reg;
            if (hit_reg) begin
                reg_hold_q <= reg_rdata_i;
            end
        end
    end

    // Drive output only for an enabled read with output enable.
    always_comb begin
        drive_o = acc_en & oe_i & ~wr_i;
        rdata_o = '0;
        if (drive_o) begin
            rdata_o = src_reg_q ? reg_hold_q : ram_rdata_i;
        end
    end
endmodule

// File: rtl/clkreg_regfile.sv
// Control register and user copy of the time registers.
// The user copy follows the external counter, holds while a control bit is set,
// refreshes on the tick after release, and hands staged values to the counter
// when the set bit clears. Assumes tick_i is a single-clock strobe.
module clkreg_regfile
    import clkreg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en_i,
    input  logic [2:0] wr_idx_i,
    input  logic [7:0] wr_data_i,
    input  logic [2:0] rd_idx_i,
    output logic [7:0] rd_data_o,
    input  logic      tick_i,
    input  time_vec_t cnt_now_i,
    output logic      cnt_load_o,
    output time_vec_t cnt_load_val_o,
    output ctl_t      ctl_o,
    output time_vec_t user_o
);
    ctl_t      ctl_q;
    ctl_t      ctl_new;
    logic      pend_q;
    time_vec_t user_q;
    logic      load_q;
    time_vec_t load_val_q;

    logic       ctl_wr;
    logic       frozen;
    logic       unfreeze;
    logic       commit;
    logic       follow;
    logic [2:0] wr_slot;
    logic [2:0] rd_slot;

    assign ctl_wr   = wr_en_i && (wr_idx_i == 3'd0);
    assign ctl_new  = '{set_b: wr_data_i[7], frz_b: wr_data_i[6]};
    assign frozen   = ctl_q.set_b | ctl_q.frz_b;
    assign unfreeze = ctl_wr && frozen && !ctl_new.set_b && !ctl_new.frz_b;
    assign commit   = ctl_wr && ctl_q.set_b && !ctl_new.set_b;
    assign follow   = !frozen && (!pend_q || tick_i);
    assign wr_slot  = wr_idx_i - 3'd1;
    assign rd_slot  = rd_idx_i - 3'd1;

    // Control bits and the pending-refresh flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (ctl_wr) begin
                ctl_q <= ctl_new;
            end
            if (unfreeze) begin
                pend_q <= 1'b1;
            end else if (!frozen && pend_q && tick_i) begin
                pend_q <= 1'b0;
            end
        end
    end

    // User copy: follow the counter, or accept staged host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            user_q <= '0;
        end else if (follow) begin
            user_q <= mask_time(cnt_now_i);
        end else if (wr_en_i && (wr_idx_i != 3'd0) && ctl_q.set_b) begin
            user_q[wr_slot] <= wr_data_i & time_field_mask(wr_slot);
        end
    end

    // One-clock load strobe carrying the staged values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q     <= 1'b0;
            load_val_q <= '0;
        end else begin
            load_q <= commit;
            if (commit) begin
                load_val_q <= user_q;
            end
        end
    end

    // Read data for the selected register.
    always_comb begin
        if (rd_idx_i == 3'd0) begin
            rd_data_o = {ctl_q.set_b, ctl_q.frz_b, 6'b0};
        end else begin
            rd_data_o = user_q[rd_slot];
        end
    end

    assign cnt_load_o     = load_q;
    assign cnt_load_val_o = load_val_q;
    assign ctl_o          = ctl_q;
    assign user_o         = user_q;
endmodule

// File: rtl/clkreg_mem.sv
// Top level: a byte-wide memory window with the clock registers in the top
// eight addresses and a RAM array behind all other addresses.
// Assumes an external BCD counter that advances on tick_i and loads on cnt_load_o.
module clkreg_mem
    import clkreg_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int RAM_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_fail_i,
    output logic              pwr_fail_n_o,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic              bus_oe_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic              bus_drive_o,
    input  logic              tick_i,
    input  logic [55:0]       cnt_now_i,
    output logic              cnt_load_o,
    output logic [55:0]       cnt_load_val_o
);
    logic              ram_we;
    logic              ram_re;
    logic [RAM_AW-1:0] ram_addr;
    logic [7:0]        ram_rdata;
    logic              reg_we;
    logic [2:0]        reg_idx;
    logic [7:0]        reg_rdata;
    ctl_t              ctl_s;
    time_vec_t         user_s;
    time_vec_t         load_val_s;
    logic              ctl_set_bit;
    logic              ctl_frz_bit;
    logic [55:0]       user_vec;

    assign pwr_fail_n_o   = ~pwr_fail_i;
    assign ctl_set_bit    = ctl_s.set_b;
    assign ctl_frz_bit    = ctl_s.frz_b;
    assign user_vec       = user_s;
    assign cnt_load_val_o = load_val_s;

    clkreg_bus #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (bus_sel_i),
        .wr_i       (bus_wr_i),
        .oe_i       (bus_oe_i),
        .pf_i       (pwr_fail_i),
        .addr_i     (bus_addr_i),
        .ram_rdata_i(ram_rdata),
        .reg_rdata_i(reg_rdata),
        .ram_we_o   (ram_we),
        .ram_re_o   (ram_re),
        .ram_addr_o (ram_addr),
        .reg_we_o   (reg_we),
        .reg_idx_o  (reg_idx),
        .drive_o    (bus_drive_o),
        .rdata_o    (bus_rdata_o)
    );

    clkreg_sram #(.AW(RAM_AW), .DW(8)) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (ram_we),
        .re_i   (ram_re),
        .addr_i (ram_addr),
        .wdata_i(bus_wdata_i),
        .rdata_o(ram_rdata)
    );

    clkreg_regfile u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (reg_we),
        .wr_idx_i      (reg_idx),
        .wr_data_i     (bus_wdata_i),
        .rd_idx_i      (reg_idx),
        .rd_data_o     (reg_rdata),
        .tick_i        (tick_i),
        .cnt_now_i     (time_vec_t'(cnt_now_i)),
        .cnt_load_o    (cnt_load_o),
        .cnt_load_val_o(load_val_s),
        .ctl_o         (ctl_s),
        .user_o        (user_s)
    );
endmodule

// File: rtl/clkreg_mem_chk.sv
// Property checker for clkreg_mem, attached with bind.
// Observes ports and the decoder, control and user-copy signals.
module clkreg_mem_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pf_i,
    input logic        ram_we,
    input logic        reg_we,
    input logic        drive,
    input logic [7:0]  rdata,
    input logic        cnt_load,
    input logic        ctl_set,
    input logic        ctl_frz,
    input logic [55:0] user
);
    // R10: power fail suppresses every write
    a_r10_pf_blocks_writes: assert property (@(posedge clk) disable iff (!rst_n)
        pf_i |-> (!ram_we && !reg_we));

    // R10: power fail suppresses the read output
    a_r10_pf_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        pf_i |-> !drive);

    // R3: undriven bus reads zero
    a_r3_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |-> (rdata == 8'h00));

    // R8: load strobe lasts one clock
    a_r8_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> !cnt_load);

    // R8: load strobe only follows a set-bit release
    a_r8_load_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |-> (!ctl_set && $past(ctl_set)));

    // R4: frozen copy does not move
    a_r4_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_frz) && !$past(ctl_set)) |-> $stable(user));
endmodule

bind clkreg_mem clkreg_mem_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pf_i    (pwr_fail_i),
    .ram_we  (ram_we),
    .reg_we  (reg_we),
    .drive   (bus_drive_o),
    .rdata   (bus_rdata_o),
    .cnt_load(cnt_load_o),
    .ctl_set (ctl_set_bit),
    .ctl_frz (ctl_frz_bit),
    .user    (user_vec)
);

// File: tb/clkreg_mem_tb.sv
// Self-checking bench for clkreg_mem, with a behavioural external counter.
module clkreg_mem_tb;
    localparam int ADDR_W = 15;
    localparam int RAM_AW = 11;
    localparam logic [14:0] A_CTL = 15'h7FF8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_fail_i = 1'b0;
    logic        pwr_fail_n_o;
    logic        bus_sel_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic        bus_oe_i = 1'b0;
    logic [14:0] bus_addr_i = '0;
    logic [7:0]  bus_wdata_i = '0;
    logic [7:0]  bus_rdata_o;
    logic        bus_drive_o;
    logic        tick_i = 1'b0;
    logic [55:0] cnt = '0;
    logic        cnt_load_o;
    logic [55:0] cnt_load_val_o;

    int nchk = 0;
    int nfail = 0;
    int load_cnt = 0;
    logic [55:0] load_seen = '0;
    logic [7:0] mem_m [0:(1<<RAM_AW)-1];
    bit         vld_m [0:(1<<RAM_AW)-1];

    always #4 clk = ~clk;

    clkreg_mem #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_fail_i(pwr_fail_i), .pwr_fail_n_o(pwr_fail_n_o),
        .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_oe_i(bus_oe_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .bus_drive_o(bus_drive_o), .tick_i(tick_i), .cnt_now_i(cnt),
        .cnt_load_o(cnt_load_o), .cnt_load_val_o(cnt_load_val_o)
    );

    // External counter: loads on strobe, otherwise counts on tick.
    always @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (cnt_load_o) cnt <= cnt_load_val_o;
        else if (tick_i) cnt <= cnt + 56'd1;
    end

    // Load strobe monitor.
    always @(posedge clk) begin
        if (rst_n && cnt_load_o) begin
            load_cnt = load_cnt + 1;
            load_seen = cnt_load_val_o;
        end
    end

    function automatic logic [7:0] bmask(input int k);
        case (k)
            1: return 8'h7F; 2: return 8'h7F; 3: return 8'h3F; 4: return 8'h07;
            5: return 8'h3F; 6: return 8'h1F; default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] exp_reg(input logic [55:0] c, input int k);
        return c[8*(k-1) +: 8] & bmask(k);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic pulse_tick();
        tick_i = 1'b1; @(posedge clk); @(negedge clk); tick_i = 1'b0;
    endtask

    task automatic bus_write(input logic [14:0] a, input logic [7:0] d);
        bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_oe_i = 1'b0; bus_addr_i = a; bus_wdata_i = d;
        @(posedge clk); @(negedge clk);
        bus_sel_i = 1'b0; bus_wr_i = 1'b0;
    endtask

    task automatic bus_read(input logic [14:0] a, input bit tk, output logic [7:0] d);
        bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_oe_i = 1'b1; bus_addr_i = a; tick_i = tk;
        @(posedge clk); @(negedge clk);
        tick_i = 1'b0;
        d = bus_rdata_o;
        bus_sel_i = 1'b0; bus_oe_i = 1'b0;
    endtask

    task automatic ram_wr(input logic [14:0] a, input logic [7:0] d);
        bus_write(a, d);
        mem_m[a[RAM_AW-1:0]] = d;
        vld_m[a[RAM_AW-1:0]] = 1'b1;
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_up();
    end

    initial begin
        logic [7:0]  rd;
        logic [55:0] snap;
        logic [55:0] staged;
        logic [55:0] old_c;
        void'($urandom(32'd2024));
        for (int i = 0; i < (1 << RAM_AW); i++) vld_m[i] = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // Reset state
        check("R10 reset pf_n", 64'(pwr_fail_n_o), 64'd1);
        check("R3 reset drive", 64'(bus_drive_o), 64'd0);
        bus_read(A_CTL, 0, rd);
        check("R9 reset control", 64'(rd), 64'h00);
        bus_read(15'h7FF9, 0, rd);
        check("R6 reset seconds", 64'(rd), 64'h00);

        // Directed RAM, including the top RAM byte and aliasing (R1, R2)
        ram_wr(15'h0000, 8'hA5);
        ram_wr(15'h7FF7, 8'h3C);
        bus_read(15'h0000, 0, rd); check("R2 ram low", 64'(rd), 64'hA5);
        bus_read(15'h7FF7, 0, rd); check("R1 ram top", 64'(rd), 64'h3C);
        ram_wr(15'h0001, 8'h11);
        ram_wr(15'h0801, 8'h22);
        bus_read(15'h0001, 0, rd); check("R1 alias", 64'(rd), 64'h22);

        // Random RAM traffic with random ticks (R2)
        for (int i = 0; i < 400; i++) begin
            logic [14:0] a;
            a = 15'($urandom % 32760);
            if ($urandom % 3 == 0) begin
                pulse_tick();
            end else if ($urandom % 2 == 0) begin
                ram_wr(a, 8'($urandom));
            end else begin
                bus_read(a, 0, rd);
                if (vld_m[a[RAM_AW-1:0]]) check("R2 random ram", 64'(rd), 64'(mem_m[a[RAM_AW-1:0]]));
            end
        end

        // Free-running copy, random register reads (R6, R9)
        for (int i = 0; i < 60; i++) begin
            int k;
            if ($urandom % 2 == 0) begin pulse_tick(); idle(1); end
            k = 1 + int'($urandom % 7);
            bus_read(15'h7FF8 + 15'(k), 0, rd);
            check("R6 follow counter", 64'(rd), 64'(exp_reg(cnt, k)));
        end

        // Set bit: stage values with unused bits high (R7, R9)
        bus_write(A_CTL, 8'h80);
        bus_read(A_CTL, 0, rd); check("R7 control set", 64'(rd), 64'h80);
        staged = 56'hE9_DA_FB_FC_ED_FE_FF;
        for (int k = 1; k <= 7; k++) bus_write(15'h7FF8 + 15'(k), staged[8*(k-1) +: 8]);
        pulse_tick(); pulse_tick(); pulse_tick();
        for (int k = 1; k <= 7; k++) begin
            bus_read(15'h7FF8 + 15'(k), 0, rd);
            check("R9 staged masked", 64'(rd), 64'(exp_reg(staged, k)));
        end
        for (int k = 1; k <= 7; k++) staged[8*(k-1) +: 8] = exp_reg(staged, k);
        bus_write(A_CTL, 8'h00);
        idle(2);
        check("R8 single load", 64'(load_cnt), 64'd1);
        check("R8 load value", 64'(load_seen), 64'(staged));
        check("R8 counter loaded", 64'(cnt), 64'(staged));
        pulse_tick(); idle(1);
        bus_read(15'h7FF9, 0, rd);
        check("R5 refresh after set", 64'(rd), 64'(exp_reg(cnt, 1)));

        // Write to time register with set bit clear is ignored (R7)
        bus_write(15'h7FFA, 8'h55);
        idle(1);
        bus_read(15'h7FFA, 0, rd);
        check("R7 write ignored", 64'(rd), 64'(exp_reg(cnt, 2)));
        check("R8 no extra load", 64'(load_cnt), 64'd1);

        // Freeze bit (R4), pending refresh (R5), tick-read collision (R11)
        idle(2);
        snap = cnt;
        bus_write(A_CTL, 8'h40);
        pulse_tick(); pulse_tick(); pulse_tick(); pulse_tick();
        bus_read(15'h7FF9, 0, rd); check("R4 frozen seconds", 64'(rd), 64'(exp_reg(snap, 1)));
        bus_read(A_CTL, 0, rd);   check("R4 control freeze", 64'(rd), 64'h40);
        bus_write(A_CTL, 8'h00);
        idle(2);
        bus_read(15'h7FF9, 0, rd); check("R5 held until tick", 64'(rd), 64'(exp_reg(snap, 1)));
        bus_read(15'h7FF9, 1, rd); check("R11 pending tick read", 64'(rd), 64'(exp_reg(snap, 1)));
        idle(1);
        for (int k = 1; k <= 7; k++) begin
            bus_read(15'h7FF8 + 15'(k), 0, rd);
            check("R5 all refreshed", 64'(rd), 64'(exp_reg(cnt, k)));
        end
        idle(2);
        old_c = cnt;
        bus_read(15'h7FF9, 1, rd); check("R11 free tick read", 64'(rd), 64'(exp_reg(old_c, 1)));
        idle(1);
        bus_read(15'h7FF9, 0, rd); check("R11 after tick", 64'(rd), 64'(exp_reg(old_c + 56'd1, 1)));

        // Unused control bits (R9)
        bus_write(A_CTL, 8'h3F);
        bus_read(A_CTL, 0, rd); check("R9 control unused", 64'(rd), 64'h00);
        bus_write(A_CTL, 8'h7F);
        bus_read(A_CTL, 0, rd); check("R9 control partial", 64'(rd), 64'h40);
        bus_write(A_CTL, 8'h00);
        pulse_tick(); idle(1);

        // Power fail (R10)
        ram_wr(15'h0010, 8'h42);
        pwr_fail_i = 1'b1;
        idle(1);
        check("R10 pf_n low", 64'(pwr_fail_n_o), 64'd0);
        bus_write(15'h0010, 8'h99);
        bus_write(A_CTL, 8'h80);
        bus_sel_i = 1'b1; bus_oe_i = 1'b1; bus_addr_i = 15'h0010;
        @(posedge clk); @(negedge clk);
        check("R10 no drive", 64'(bus_drive_o), 64'd0);
        check("R10 rdata zero", 64'(bus_rdata_o), 64'h00);
        bus_sel_i = 1'b0; bus_oe_i = 1'b0;
        pwr_fail_i = 1'b0;
        idle(1);
        check("R10 pf_n high", 64'(pwr_fail_n_o), 64'd1);
        bus_read(15'h0010, 0, rd); check("R10 ram kept", 64'(rd), 64'h42);
        bus_read(A_CTL, 0, rd);    check("R10 control kept", 64'(rd), 64'h00);

        // Output enable gating (R3)
        bus_sel_i = 1'b1; bus_oe_i = 1'b0; bus_addr_i = 15'h0010;
        @(posedge clk); @(negedge clk);
        check("R3 oe low drive", 64'(bus_drive_o), 64'd0);
        check("R3 oe low data", 64'(bus_rdata_o), 64'h00);
        bus_wr_i = 1'b1; bus_oe_i = 1'b1; bus_wdata_i = 8'h42;
        #1;
        check("R3 write no drive", 64'(bus_drive_o), 64'd0);
        @(posedge clk); @(negedge clk);
        bus_sel_i = 1'b0; bus_wr_i = 1'b0; bus_oe_i = 1'b0;

        finish_up();
    end
endmodule